// File: doc/BRIEF.md
# Acquisition Record Save Controller

This block runs the full-rate save phase of a digitizing front end. Once a start pulse arrives, it takes ownership of the acquisition memory. It then issues one memory write for every tick of a free-running write clock enable, and it interleaves the channels so that consecutive writes alternate between them. An address counter supplies each write location. A record-end register captures every address that is written, so that a later readout can find where the record started in the circular memory.

When the configured number of points has been stored for every channel, the controller stops writing and hands the memory back to the processor. In the same cycle it pulses a completion strobe. The address is not cleared between records. Each new record continues from where the previous one left off and wraps modulo the memory depth.

Top module: `acq_save_ctrl`

## Requirements
- R1: A synchronous reset, active high, sets `own_acq_o`, `mem_we_o` and `done_o` to 0 and sets `mem_addr_o`, `mem_ch_o` and `rec_end_o` to 0.
- R2: A `start_i` pulse while the processor owns the memory (`own_acq_o`=0) sets `own_acq_o` to 1 in the next cycle.
- R3: `mem_we_o` is high in exactly those cycles in which `own_acq_o`=1 and `wr_ce_i`=1.
- R4: Every write advances `mem_addr_o` by one in the following cycle. A cycle without a write leaves `mem_addr_o` unchanged.
- R5: In the cycle after a write, `rec_end_o` holds the address used by that write. Otherwise `rec_end_o` keeps its value.
- R6: `mem_ch_o` is 0 on the first write of a record. It then steps 0, 1, …, CHANNELS-1 and back to 0 on successive writes.
- R7: After exactly CHANNELS×POINTS writes (2×1024 by default), `own_acq_o` returns to 0 in the next cycle and no further writes occur.
- R8: `done_o` is high for exactly one cycle, which is the cycle right after the final write of a record.
- R9: A `start_i` pulse while a record is being saved is ignored, so the record length still counts from the first start.
- R10: The address wraps from DEPTH-1 to 0. A new record begins at the address that follows the previous record's last write.
- R11: `wr_ce_i` ticks while the processor owns the memory produce no write and leave the address and record-end unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Save-enable pulse from the time base |
| wr_ce_i | input | 1 | Free-running write clock enable (write pace) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_ch_o | output | CH_W | Channel of the current write |
| own_acq_o | output | 1 | 1 = acquisition path owns memory, 0 = processor |
| rec_end_o | output | ADDR_W | Address of the most recent write |
| done_o | output | 1 | One-cycle record-complete strobe |

## Verification
The bench uses a memory depth that is not a multiple of the record length, which makes the address wrap in the middle of a record. A design that wraps at a power of two, or that clears the address on every start, then writes to the wrong locations. Write pacing with gaps exposes two kinds of fault: a counter that moves without a write, and a record-end register that is loaded on every cycle. A second start in the middle of a record catches a controller that restarts its count and so produces an overlong record. Ticks while the processor owns the memory, and a reset applied in the middle of a record, catch writes outside ownership and state that the reset does not clear.

// File: rtl/acq_save_pkg.sv
package acq_save_pkg;

  typedef enum logic [0:0] {
    SV_IDLE = 1'b0,
    SV_SAVE = 1'b1
  } save_state_e;

  // Width needed to hold values 0..n-1, never less than one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/acq_save_fsm.sv
module acq_save_fsm
  import acq_save_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic wr_fire_i,
  input  logic last_i,
  output logic own_o,
  output logic start_take_o,
  output logic done_o
);

  save_state_e state_q, state_d;
  logic        done_q;

  assign start_take_o = (state_q == SV_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SV_IDLE: if (start_i) state_d = SV_SAVE;
      SV_SAVE: if (wr_fire_i && last_i) state_d = SV_IDLE;
      default: state_d = SV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SV_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= wr_fire_i && last_i;
    end
  end

  assign own_o  = (state_q == SV_SAVE);
  assign done_o = done_q;

endmodule

// File: rtl/acq_sample_ctr.sv
module acq_sample_ctr #(
  parameter int unsigned CHANNELS = 2,
  parameter int unsigned POINTS   = 1024,
  localparam int unsigned CH_W    = acq_save_pkg::idx_width(CHANNELS),
  localparam int unsigned PT_W    = acq_save_pkg::idx_width(POINTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear_i,
  input  logic            adv_i,
  output logic [CH_W-1:0] ch_o,
  output logic            last_o
);

  localparam logic [CH_W-1:0] CH_LAST = CH_W'(CHANNELS - 1);
  localparam logic [PT_W-1:0] PT_LAST = PT_W'(POINTS - 1);

  logic [CH_W-1:0] ch_q;
  logic [PT_W-1:0] pt_q;
  logic            ch_wrap;

  assign ch_wrap = (ch_q == CH_LAST);
  assign last_o  = ch_wrap && (pt_q == PT_LAST);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      ch_q <= '0;
      pt_q <= '0;
    end else if (adv_i) begin
      if (last_o) begin
        ch_q <= '0;
        pt_q <= '0;
      end else if (ch_wrap) begin
        ch_q <= '0;
        pt_q <= pt_q + 1'b1;
      end else begin
        ch_q <= ch_q + 1'b1;
      end
    end
  end

  assign ch_o = ch_q;

endmodule

// File: rtl/acq_addr_ctr.sv
module acq_addr_ctr #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] rec_end_o
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a == TOP) ? '0 : a + 1'b1;
  endfunction

  logic [ADDR_W-1:0] addr_q, end_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      end_q  <= '0;
    end else if (adv_i) begin
      end_q  <= addr_q;
      addr_q <= step_addr(addr_q);
    end
  end

  assign addr_o    = addr_q;
  assign rec_end_o = end_q;

endmodule

// File: rtl/acq_save_ctrl.sv
module acq_save_ctrl #(
  parameter int unsigned CHANNELS = 2,
  parameter int unsigned POINTS   = 1024,
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned DEPTH    = 2048,
  localparam int unsigned CH_W    = acq_save_pkg::idx_width(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              wr_ce_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [CH_W-1:0]   mem_ch_o,
  output logic              own_acq_o,
  output logic [ADDR_W-1:0] rec_end_o,
  output logic              done_o
);

  logic wr_fire;
  logic last_write;
  logic start_take;
  logic own;

  assign wr_fire = own && wr_ce_i;

  acq_save_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .wr_fire_i   (wr_fire),
    .last_i      (last_write),
    .own_o       (own),
    .start_take_o(start_take),
    .done_o      (done_o)
  );

  acq_sample_ctr #(.CHANNELS(CHANNELS), .POINTS(POINTS)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clear_i(start_take),
    .adv_i  (wr_fire),
    .ch_o   (mem_ch_o),
    .last_o (last_write)
  );

  acq_addr_ctr #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (wr_fire),
    .addr_o   (mem_addr_o),
    .rec_end_o(rec_end_o)
  );

  assign mem_we_o  = wr_fire;
  assign own_acq_o = own;

endmodule

// File: rtl/acq_save_ctrl_chk.sv
module acq_save_ctrl_chk #(
  parameter int unsigned CHANNELS = 2,
  parameter int unsigned POINTS   = 1024,
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned DEPTH    = 2048
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              wr_ce_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              own_acq_o,
  input logic [ADDR_W-1:0] rec_end_o,
  input logic              done_o
);

  localparam int unsigned TOTAL = CHANNELS * POINTS;

  int unsigned wr_seen;

  always_ff @(posedge clk) begin
    if (rst || (!own_acq_o && start_i)) wr_seen <= 0;
    else if (mem_we_o) wr_seen <= wr_seen + 1;
  end

  function automatic logic [ADDR_W-1:0] nxt(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!own_acq_o && !done_o && mem_addr_o == '0 && rec_end_o == '0));

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!own_acq_o && start_i) |=> own_acq_o);

  p_we_own_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (own_acq_o && wr_ce_i));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> (mem_addr_o == nxt($past(mem_addr_o))));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_o |=> $stable(mem_addr_o));

  p_rec_end_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> (rec_end_o == $past(mem_addr_o)));

  p_length_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(own_acq_o) |-> (wr_seen == TOTAL));

  p_done_edge_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $fell(own_acq_o));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_no_overrun_r9: assert property (@(posedge clk) disable iff (rst)
    own_acq_o |-> (wr_seen < TOTAL));

endmodule

bind acq_save_ctrl acq_save_ctrl_chk #(
  .CHANNELS(CHANNELS), .POINTS(POINTS), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .wr_ce_i   (wr_ce_i),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .own_acq_o (own_acq_o),
  .rec_end_o (rec_end_o),
  .done_o    (done_o)
);

// File: tb/acq_save_ctrl_tb.sv
`timescale 1ns/1ps
module acq_save_ctrl_tb;

  localparam int unsigned CHANNELS = 2;
  localparam int unsigned POINTS   = 1024;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DEPTH    = 3000;
  localparam int unsigned TOTAL    = CHANNELS * POINTS;
  localparam int unsigned NREC     = 4;

  // Record vectors: write-enable period, whether a second start is sent
  // mid-record, and the number of writes expected in the record.
  localparam int unsigned PERIOD [NREC] = '{1, 3, 2, 1};
  localparam bit          MIDST  [NREC] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam int unsigned EXPWR  [NREC] = '{TOTAL, TOTAL, TOTAL, TOTAL};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic              wr_ce_i = 1'b0;
  logic              mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [0:0]        mem_ch_o;
  logic              own_acq_o;
  logic [ADDR_W-1:0] rec_end_o;
  logic              done_o;

  always #2.5 clk = ~clk;

  acq_save_ctrl #(.CHANNELS(CHANNELS), .POINTS(POINTS), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .wr_ce_i(wr_ce_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_ch_o(mem_ch_o),
    .own_acq_o(own_acq_o), .rec_end_o(rec_end_o), .done_o(done_o)
  );

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          ended  = 1'b0;

  int unsigned e_addr, e_end, e_ch, e_cnt;
  bit          e_own, e_done;
  int unsigned wr_obs;

  task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic model_clear();
    e_addr = 0; e_end = 0; e_ch = 0; e_cnt = 0; e_own = 0; e_done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start_i = 1'b0; wr_ce_i = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; wr_ce_i = 1'b0;
    model_clear();
    #1;
    chk(own_acq_o == 1'b0, "R1 owner after reset", own_acq_o, 0);
    chk(mem_we_o == 1'b0,  "R1 write after reset", mem_we_o, 0);
    chk(done_o == 1'b0,    "R1 done after reset", done_o, 0);
    chk(mem_addr_o == '0,  "R1 address after reset", mem_addr_o, 0);
    chk(rec_end_o == '0,   "R1 record end after reset", rec_end_o, 0);
    chk(mem_ch_o == '0,    "R1 channel after reset", mem_ch_o, 0);
  endtask

  // One cycle: drive at the falling edge, check, then advance the model
  // to what the next rising edge must produce.
  task automatic step(input bit s, input bit ce);
    bit wr;
    @(negedge clk);
    start_i = s; wr_ce_i = ce;
    #1;
    wr = e_own && ce;
    chk(own_acq_o == e_own,  "R2/R7 owner", own_acq_o, e_own);
    chk(mem_we_o == wr,      "R3/R11 write strobe", mem_we_o, wr);
    chk(mem_addr_o == e_addr, "R4/R10 address", mem_addr_o, e_addr);
    chk(rec_end_o == e_end,  "R5 record end", rec_end_o, e_end);
    chk(done_o == e_done,    "R8 done strobe", done_o, e_done);
    if (wr) begin
      chk(mem_ch_o == e_ch, "R6 channel", mem_ch_o, e_ch);
      wr_obs++;
    end
    e_done = 0;
    if (wr) begin
      e_end  = e_addr;
      e_addr = (e_addr + 1 == DEPTH) ? 0 : e_addr + 1;
      e_ch   = (e_ch + 1) % CHANNELS;
      e_cnt++;
      if (e_cnt == TOTAL) begin
        e_own = 0; e_done = 1; e_cnt = 0; e_ch = 0;
      end
    end else if (!e_own && s) begin
      e_own = 1; e_cnt = 0; e_ch = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finish_run();
  end

  initial begin
    model_clear();
    wr_obs = 0;
    do_reset();

    // Idle ticks before any start must not write (R11).
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);

    for (int r = 0; r < NREC; r++) begin
      int unsigned k;
      wr_obs = 0;
      step(1'b1, 1'b0);
      k = 0;
      while (e_own && k < 20000) begin
        step(MIDST[r] && (k == 100 || k == 101), (k % PERIOD[r]) == 0);
        k++;
      end
      step(1'b0, 1'b1); // done strobe cycle, ticks ignored while idle
      chk(wr_obs == EXPWR[r], MIDST[r] ? "R9 length with repeat start" : "R7 record length",
          wr_obs, EXPWR[r]);
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
      chk(mem_addr_o == e_addr, "R11 address held while idle", mem_addr_o, e_addr);
    end

    // Record 2 spans 2048..(4096 mod 3000); the address must have wrapped (R10).
    chk(e_addr == (NREC * TOTAL) % DEPTH, "R10 final address", mem_addr_o, (NREC * TOTAL) % DEPTH);

    // Reset in the middle of a record (R1).
    step(1'b1, 1'b0);
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1);
    do_reset();
    step(1'b0, 1'b1);

    finish_run();
  end

endmodule